// File: doc/BRIEF.md
# Block-Copy DMA Engine with Completion Interrupt

This engine copies a run of equal-sized blocks between a block-storage area and a host buffer. Both sit in one flat byte address space reached through a request/acknowledge memory port. Software programs the configuration through a small 32-bit register bus:

- the log2 of the block size,
- the storage base and the memory size, both counted in blocks,
- the starting block address,
- the host byte address.

A write to the count register then launches the copy. Bit 31 of that write sets the direction and the low 16 bits give the number of blocks.

While the copy runs, the count register counts down, one block at a time. It reads zero when the job has finished. Errors gather in a five-bit status register whose bits software clears by writing 1 to them. A finished job raises a pending flag. When its enable bit is set, that flag drives the card's single interrupt line, which is shared by an OR with a second interrupt input from elsewhere on the card.

Top module: `blkcopy_dma`

## Requirements
- R1: After reset every register reads 0, `irq_out` follows only `aux_irq`, and `mem_req` stays low.
- R2: With count bit 31 = 0, the engine copies `count << (shift-2)` words. The source is storage starting at byte `(base + block_address) << shift` and the destination is host memory starting at the host byte address, one ascending word at a time. No other word changes.
- R3: With count bit 31 = 1, the same copy runs the other way, from the host buffer into storage.
- R4: The count register (offset 0x18) reads `{dir, 15'b0, count[15:0]}`. The count drops by exactly one as the last word of each block is written, and reads 0 when the job completes.
- R5: A count write whose low 16 bits are zero starts nothing: no memory request is made and the status stays 0.
- R6: While a copy is running, writes to offsets 0x00, 0x04, 0x08, 0x10, 0x14 and 0x18 are dropped and set status bit 0.
- R7: A memory error response (`mem_err` during an acknowledge) sets status bit 1 and stops the copy at once. The erroring write is not applied, the remaining block count stays readable, and the completion flag is not raised.
- R8: A launch is refused, with nothing copied and the count left as written, when any start check fails. The checks are: shift below 2 sets status bit 2; `base + block_address + count` above the memory size sets status bit 3; a host address that is not a multiple of the block size sets status bit 4. A job that ends exactly at the memory size is accepted.
- R9: Writing to status (offset 0x2C) clears each bit written as 1 and leaves the other bits as they were.
- R10: Completion sets bit 0 of offset 0x34, whatever the enable. In the control register (offset 0x0C), bit 0 is the enable and reads back. Writing bit 1 as 1 clears the pending flag, and bit 1 always reads 0. The engine's contribution to the interrupt line is pending AND enable.
- R11: `irq_out` is high whenever `aux_irq` is high.
- R12: Each memory request holds its address, direction and write data steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, valid together with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid together with `mem_ack` |
| aux_irq | input | 1 | Second interrupt source sharing the line |
| irq_out | output | 1 | Shared interrupt line |

## Verification
The properties assume that `mem_ack` comes only while `mem_req` is high, that `mem_err` is meaningful only together with `mem_ack`, and that `mem_rdata` is valid in the acknowledge cycle. The bench memory model ensures this by computing its acknowledge from the current request at each falling edge, and in stall mode it acknowledges only every other cycle. The properties also assume that software does not program blocks smaller than a word when it expects data to move. The stimulus only launches copies with shift 4, and uses smaller shifts only to check that the launch is refused.

// File: rtl/blkcopy_pkg.sv
`timescale 1ns/1ps
package blkcopy_pkg;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int CNT_W = 16;
  localparam int SH_W  = 5;
  localparam int ERR_W = 5;
  localparam int RA_W  = 8;
  localparam int DIR_BIT = 31;

  // register byte offsets
  localparam logic [RA_W-1:0] RG_SHIFT = 8'h00;
  localparam logic [RA_W-1:0] RG_BASE  = 8'h04;
  localparam logic [RA_W-1:0] RG_MSIZE = 8'h08;
  localparam logic [RA_W-1:0] RG_ICTL  = 8'h0C;
  localparam logic [RA_W-1:0] RG_BLK   = 8'h10;
  localparam logic [RA_W-1:0] RG_HOST  = 8'h14;
  localparam logic [RA_W-1:0] RG_CNT   = 8'h18;
  localparam logic [RA_W-1:0] RG_STAT  = 8'h2C;
  localparam logic [RA_W-1:0] RG_ISTAT = 8'h34;

  // status bit positions
  localparam int EB_BUSY  = 0;
  localparam int EB_BUS   = 1;
  localparam int EB_SMALL = 2;
  localparam int EB_RANGE = 3;
  localparam int EB_ALIGN = 4;

  localparam int WORD_BYTES = DW / 8;
  localparam int MIN_SHIFT  = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_t;

  function automatic logic [AW-1:0] blk_mask(input logic [SH_W-1:0] sh);
    return (AW'(1) << sh) - AW'(1);
  endfunction

  function automatic logic [AW-1:0] store_byte_addr(input logic [AW-1:0] base,
                                                    input logic [AW-1:0] blk,
                                                    input logic [SH_W-1:0] sh);
    return (base + blk) << sh;
  endfunction

  function automatic logic host_misaligned(input logic [AW-1:0] host,
                                           input logic [SH_W-1:0] sh);
    return |(host & blk_mask(sh));
  endfunction

  function automatic logic range_exceeded(input logic [AW-1:0] base,
                                          input logic [AW-1:0] blk,
                                          input logic [CNT_W-1:0] cnt,
                                          input logic [AW-1:0] msize);
    logic [AW+1:0] last;
    last = (AW+2)'(base) + (AW+2)'(blk) + (AW+2)'(cnt);
    return last > (AW+2)'(msize);
  endfunction
endpackage

// File: rtl/blkcopy_regs.sv
`timescale 1ns/1ps
module blkcopy_regs
  import blkcopy_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             active,
  input  logic [CNT_W-1:0] count,
  input  logic             dir,
  input  logic [ERR_W-1:0] status,
  input  logic             irq_en,
  input  logic             irq_pend,
  output logic [SH_W-1:0]  cfg_shift,
  output logic [AW-1:0]    cfg_base,
  output logic [AW-1:0]    cfg_msize,
  output logic [AW-1:0]    cfg_blk,
  output logic [AW-1:0]    cfg_host,
  output logic             cnt_wr,
  output logic             busy_err,
  output logic             ictl_wr,
  output logic [ERR_W-1:0] stat_clr
);
  logic guarded;
  logic wr_ok;

  always_comb begin
    guarded = (reg_addr == RG_SHIFT) || (reg_addr == RG_BASE) ||
              (reg_addr == RG_MSIZE) || (reg_addr == RG_BLK)  ||
              (reg_addr == RG_HOST)  || (reg_addr == RG_CNT);
    busy_err = reg_wr && guarded && active;
    wr_ok    = reg_wr && !(guarded && active);
    cnt_wr   = wr_ok && (reg_addr == RG_CNT);
    ictl_wr  = wr_ok && (reg_addr == RG_ICTL);
    stat_clr = (wr_ok && (reg_addr == RG_STAT)) ? reg_wdata[ERR_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_shift <= '0;
      cfg_base  <= '0;
      cfg_msize <= '0;
      cfg_blk   <= '0;
      cfg_host  <= '0;
    end else if (wr_ok) begin
      case (reg_addr)
        RG_SHIFT: cfg_shift <= reg_wdata[SH_W-1:0];
        RG_BASE:  cfg_base  <= reg_wdata[AW-1:0];
        RG_MSIZE: cfg_msize <= reg_wdata[AW-1:0];
        RG_BLK:   cfg_blk   <= reg_wdata[AW-1:0];
        RG_HOST:  cfg_host  <= reg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RG_SHIFT: reg_rdata = DW'(cfg_shift);
      RG_BASE:  reg_rdata = cfg_base;
      RG_MSIZE: reg_rdata = cfg_msize;
      RG_ICTL:  reg_rdata = DW'(irq_en);
      RG_BLK:   reg_rdata = cfg_blk;
      RG_HOST:  reg_rdata = cfg_host;
      RG_CNT: begin
        reg_rdata[CNT_W-1:0] = count;
        reg_rdata[DIR_BIT]   = dir;
      end
      RG_STAT:  reg_rdata = DW'(status);
      RG_ISTAT: reg_rdata = DW'(irq_pend);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/blkcopy_engine.sv
`timescale 1ns/1ps
module blkcopy_engine
  import blkcopy_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic             cnt_dir,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             busy_err,
  input  logic [ERR_W-1:0] stat_clr,
  input  logic [SH_W-1:0]  cfg_shift,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_msize,
  input  logic [AW-1:0]    cfg_blk,
  input  logic [AW-1:0]    cfg_host,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [DW-1:0]    mem_rdata,
  output logic             active,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic [ERR_W-1:0] status,
  output logic             done_evt,
  output logic             blk_evt
);
  eng_state_t       state_q;
  logic [CNT_W-1:0] count_q;
  logic             dir_q;
  logic [ERR_W-1:0] status_q;
  logic [AW-1:0]    src_q, dst_q, off_q;
  logic [SH_W-1:0]  sh_q;
  logic [DW-1:0]    buf_q;

  logic             start_req, launch, rd_ack, wr_ack, bus_err, wr_ok;
  logic [ERR_W-1:0] chk_err, err_set;
  logic [AW-1:0]    off_nx, saddr;

  always_comb begin
    start_req = cnt_wr && (cnt_val != '0);
    chk_err = '0;
    chk_err[EB_SMALL] = (cfg_shift < SH_W'(MIN_SHIFT));
    chk_err[EB_RANGE] = range_exceeded(cfg_base, cfg_blk, cnt_val, cfg_msize);
    chk_err[EB_ALIGN] = host_misaligned(cfg_host, cfg_shift);
    launch  = start_req && (chk_err == '0);
    saddr   = store_byte_addr(cfg_base, cfg_blk, cfg_shift);

    rd_ack  = (state_q == ST_RD) && mem_ack;
    wr_ack  = (state_q == ST_WR) && mem_ack;
    bus_err = (rd_ack || wr_ack) && mem_err;
    wr_ok   = wr_ack && !mem_err;
    off_nx  = off_q + AW'(WORD_BYTES);
    blk_evt = wr_ok && ((off_nx & blk_mask(sh_q)) == '0);
    done_evt = blk_evt && (count_q == CNT_W'(1));

    err_set = '0;
    if (start_req) err_set = chk_err;
    err_set[EB_BUSY] = busy_err;
    err_set[EB_BUS]  = bus_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      count_q  <= '0;
      dir_q    <= 1'b0;
      status_q <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      off_q    <= '0;
      sh_q     <= '0;
      buf_q    <= '0;
    end else begin
      status_q <= (status_q & ~stat_clr) | err_set;
      if (cnt_wr) begin
        count_q <= cnt_val;
        dir_q   <= cnt_dir;
      end
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_RD;
          off_q   <= '0;
          sh_q    <= cfg_shift;
          src_q   <= cnt_dir ? cfg_host : saddr;
          dst_q   <= cnt_dir ? saddr : cfg_host;
        end
        ST_RD: if (rd_ack) begin
          if (mem_err) state_q <= ST_IDLE;
          else begin
            buf_q   <= mem_rdata;
            state_q <= ST_WR;
          end
        end
        ST_WR: if (wr_ack) begin
          if (mem_err) state_q <= ST_IDLE;
          else begin
            off_q <= off_nx;
            if (blk_evt) count_q <= count_q - CNT_W'(1);
            state_q <= done_evt ? ST_IDLE : ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = ((state_q == ST_WR) ? dst_q : src_q) + off_q;
  assign mem_wdata = buf_q;
  assign active    = (state_q != ST_IDLE);
  assign count     = count_q;
  assign dir       = dir_q;
  assign status    = status_q;
endmodule

// File: rtl/blkcopy_irq.sv
`timescale 1ns/1ps
module blkcopy_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ictl_wr,
  input  logic [1:0] ictl_wdata,
  input  logic       done_evt,
  input  logic       aux_irq,
  output logic       irq_en,
  output logic       irq_pend,
  output logic       irq_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (ictl_wr) irq_en <= ictl_wdata[0];
      // a completion in the same cycle as a clear is kept
      if (done_evt)                       irq_pend <= 1'b1;
      else if (ictl_wr && ictl_wdata[1])  irq_pend <= 1'b0;
    end
  end

  assign irq_out = (irq_pend && irq_en) || aux_irq;
endmodule

// File: rtl/blkcopy_dma.sv
`timescale 1ns/1ps
module blkcopy_dma
  import blkcopy_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            aux_irq,
  output logic            irq_out
);
  logic             eng_active, eng_dir, done_evt, blk_evt;
  logic [CNT_W-1:0] eng_count;
  logic [ERR_W-1:0] eng_status, stat_clr;
  logic             irq_en, irq_pend;
  logic [SH_W-1:0]  cfg_shift;
  logic [AW-1:0]    cfg_base, cfg_msize, cfg_blk, cfg_host;
  logic             cnt_wr, busy_err, ictl_wr;
  logic             irq_clr_evt;

  assign irq_clr_evt = ictl_wr && reg_wdata[1];

  blkcopy_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .active(eng_active), .count(eng_count), .dir(eng_dir), .status(eng_status),
    .irq_en(irq_en), .irq_pend(irq_pend),
    .cfg_shift(cfg_shift), .cfg_base(cfg_base), .cfg_msize(cfg_msize),
    .cfg_blk(cfg_blk), .cfg_host(cfg_host),
    .cnt_wr(cnt_wr), .busy_err(busy_err), .ictl_wr(ictl_wr), .stat_clr(stat_clr)
  );

  blkcopy_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cnt_wr(cnt_wr), .cnt_dir(reg_wdata[DIR_BIT]), .cnt_val(reg_wdata[CNT_W-1:0]),
    .busy_err(busy_err), .stat_clr(stat_clr),
    .cfg_shift(cfg_shift), .cfg_base(cfg_base), .cfg_msize(cfg_msize),
    .cfg_blk(cfg_blk), .cfg_host(cfg_host),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .active(eng_active), .count(eng_count), .dir(eng_dir), .status(eng_status),
    .done_evt(done_evt), .blk_evt(blk_evt)
  );

  blkcopy_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .ictl_wr(ictl_wr), .ictl_wdata(reg_wdata[1:0]),
    .done_evt(done_evt), .aux_irq(aux_irq),
    .irq_en(irq_en), .irq_pend(irq_pend), .irq_out(irq_out)
  );
endmodule

// File: rtl/blkcopy_chk.sv
`timescale 1ns/1ps
module blkcopy_chk
  import blkcopy_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_ack,
  input logic             mem_err,
  input logic             active,
  input logic [CNT_W-1:0] count,
  input logic [ERR_W-1:0] status,
  input logic             done_evt,
  input logic             busy_err,
  input logic             irq_clr_evt,
  input logic             irq_pend,
  input logic             aux_irq,
  input logic             irq_out
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) |-> (count == $past(count)) || (count == $past(count) - CNT_W'(1)));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req);

  a_r7_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !mem_req && status[EB_BUS]);

  a_r6_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |=> status[EB_BUSY]);

  a_r10_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq_pend);

  a_r10_pend_clr: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_evt && !done_evt |=> !irq_pend);

  a_r11_aux_line: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> irq_out);
endmodule

bind blkcopy_dma blkcopy_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mem_err(mem_err),
  .active(eng_active), .count(eng_count), .status(eng_status),
  .done_evt(done_evt), .busy_err(busy_err), .irq_clr_evt(irq_clr_evt),
  .irq_pend(irq_pend), .aux_irq(aux_irq), .irq_out(irq_out)
);

// File: tb/sim_blkcopy_dma.sv
`timescale 1ns/1ps
module sim_blkcopy_dma;
  localparam logic [7:0] A_SHIFT = 8'h00, A_BASE = 8'h04, A_MSIZE = 8'h08, A_ICTL = 8'h0C,
                         A_BLK = 8'h10, A_HOST = 8'h14, A_CNT = 8'h18, A_STAT = 8'h2C,
                         A_ISTAT = 8'h34;
  localparam int MEMW = 1024;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic aux_irq = 0, irq_out;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] mem [MEMW];
  bit stall = 0, phase = 0;
  bit err_en = 0;
  logic [31:0] err_addr = 0;
  int wr_acks = 0;
  int r12_bad = 0;
  bit hold_chk = 0;
  logic [31:0] hold_addr = 0;
  logic hold_we = 0;

  always #2 clk = ~clk;

  blkcopy_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .aux_irq(aux_irq), .irq_out(irq_out)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  assign mem_err   = err_en && mem_ack && (mem_addr == err_addr);

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h00010003) ^ 32'h5A5A0000;
  endfunction

  // memory model: acknowledge decided at the falling edge, also watches request hold (R12)
  always @(negedge clk) begin
    logic nack;
    phase = ~phase;
    nack = mem_req && (!stall || phase);
    if (hold_chk && (!mem_req || mem_addr != hold_addr || mem_we != hold_we)) r12_bad++;
    hold_chk  = mem_req && !nack;
    hold_addr = mem_addr;
    hold_we   = mem_we;
    mem_ack <= nack;
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we && !mem_err) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wr_acks <= wr_acks + 1;
    end
  end

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    finish_sim();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic init_mem();
    for (int i = 0; i < MEMW; i++) mem[i] = pat(i);
  endtask

  // polls the count; each sample must equal start - completed blocks (R4)
  task automatic wait_done(input int nblk, input int wpb, input int acks0, output int bad);
    logic [31:0] d;
    bad = 1;
    for (int t = 0; t < 20000; t++) begin
      rd(A_CNT, d);
      if (int'(d[15:0]) != nblk - (wr_acks - acks0) / wpb) begin bad++; break; end
      if (d[15:0] == 16'd0) begin bad--; break; end
    end
  endtask

  task automatic copy_chk(input int src_w, input int dst_w, input int n, input string tag);
    int bad = 0;
    for (int k = 0; k < n; k++) if (mem[dst_w + k] !== pat(src_w + k)) bad++;
    if (mem[dst_w + n] !== pat(dst_w + n)) bad++;
    chk(bad == 0, tag, 32'(bad), 32'd0);
  endtask

  task automatic t_reset();
    rd_chk(A_SHIFT, 0, "R1 shift");
    rd_chk(A_BASE, 0, "R1 base");
    rd_chk(A_MSIZE, 0, "R1 msize");
    rd_chk(A_ICTL, 0, "R1 ictl");
    rd_chk(A_BLK, 0, "R1 blk");
    rd_chk(A_HOST, 0, "R1 host");
    rd_chk(A_CNT, 0, "R1 count");
    rd_chk(A_STAT, 0, "R1 status");
    rd_chk(A_ISTAT, 0, "R1 istat");
    chk(irq_out == 0 && mem_req == 0, "R1 irq/req", {30'd0, irq_out, mem_req}, 0);
  endtask

  task automatic t_read_copy();
    int bad, a0;
    init_mem();
    wr(A_SHIFT, 4); wr(A_BASE, 8); wr(A_MSIZE, 64); wr(A_BLK, 2); wr(A_HOST, 32'h200);
    a0 = wr_acks;
    wr(A_CNT, 32'h0000_0003);
    wait_done(3, 4, a0, bad);
    chk(bad == 0, "R4 count steps dir0", 32'(bad), 0);
    copy_chk(32'hA0 / 4, 32'h200 / 4, 12, "R2 storage to host");
    rd_chk(A_ISTAT, 1, "R10 pending set while disabled");
    chk(irq_out == 0, "R10 line low when disabled", {31'd0, irq_out}, 0);
  endtask

  task automatic t_write_copy();
    int bad, a0;
    init_mem();
    wr(A_ICTL, 32'h1);
    @(negedge clk);
    chk(irq_out == 1, "R10 enable shows old pending", {31'd0, irq_out}, 1);
    wr(A_ICTL, 32'h3);
    rd_chk(A_ICTL, 1, "R10 clear bit self-clears");
    rd_chk(A_ISTAT, 0, "R10 0x3 clears pending");
    stall = 1;
    wr(A_BLK, 20); wr(A_HOST, 32'h300);
    a0 = wr_acks;
    wr(A_CNT, 32'h8000_0002);
    wait_done(2, 4, a0, bad);
    chk(bad == 0, "R4 count steps dir1 stalled", 32'(bad), 0);
    copy_chk(32'h300 / 4, 32'h1C0 / 4, 8, "R3 host to storage");
    rd_chk(A_CNT, 32'h8000_0000, "R4 direction bit readback");
    @(negedge clk);
    chk(irq_out == 1, "R10 line high when enabled", {31'd0, irq_out}, 1);
    wr(A_ICTL, 32'h2);
    @(negedge clk);
    chk(irq_out == 0, "R10 0x2 drops line", {31'd0, irq_out}, 0);
    rd_chk(A_ISTAT, 0, "R10 0x2 clears pending");
    rd_chk(A_ICTL, 0, "R10 0x2 disables");
    stall = 0;
  endtask

  task automatic t_aux();
    aux_irq = 1;
    @(negedge clk);
    chk(irq_out == 1, "R11 aux drives line", {31'd0, irq_out}, 1);
    aux_irq = 0;
    @(negedge clk);
    chk(irq_out == 0, "R11 aux released", {31'd0, irq_out}, 0);
  endtask

  task automatic t_zero_count();
    int req_seen = 0;
    wr(A_CNT, 32'h8000_0000);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req) req_seen++; end
    chk(req_seen == 0, "R5 zero count no request", 32'(req_seen), 0);
    rd_chk(A_CNT, 32'h8000_0000, "R5 zero count readback");
    rd_chk(A_STAT, 0, "R5 status clean");
  endtask

  task automatic t_busy();
    int bad, a0;
    init_mem();
    stall = 1;
    wr(A_BLK, 10); wr(A_HOST, 32'h280);
    a0 = wr_acks;
    wr(A_CNT, 32'h0000_0004);
    repeat (5) @(negedge clk);
    wr(A_BLK, 5);
    wr(A_CNT, 32'h0000_0007);
    wait_done(4, 4, a0, bad);
    chk(bad == 0, "R6 count unaffected by busy write", 32'(bad), 0);
    rd_chk(A_BLK, 10, "R6 block address kept");
    rd_chk(A_STAT, 1, "R6 busy flag");
    copy_chk(32'h120 / 4, 32'h280 / 4, 16, "R6 copy intact");
    wr(A_STAT, 32'h2);
    rd_chk(A_STAT, 1, "R9 unwritten bit kept");
    wr(A_STAT, 32'h1);
    rd_chk(A_STAT, 0, "R9 written bit cleared");
    stall = 0;
  endtask

  task automatic t_bus_err();
    int req_seen = 0;
    init_mem();
    wr(A_ICTL, 32'h2);
    wr(A_BLK, 2); wr(A_HOST, 32'h200);
    err_en = 1; err_addr = 32'h210;
    wr(A_CNT, 32'h0000_0003);
    repeat (100) @(negedge clk);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req) req_seen++; end
    chk(req_seen == 0, "R7 requests stop", 32'(req_seen), 0);
    rd_chk(A_STAT, 32'h2, "R7 bus error flag");
    rd_chk(A_CNT, 32'h2, "R7 remaining count");
    rd_chk(A_ISTAT, 0, "R7 no completion");
    chk(mem[32'h210 / 4] === pat(32'h210 / 4), "R7 faulting write not applied",
        mem[32'h210 / 4], pat(32'h210 / 4));
    err_en = 0;
    wr(A_STAT, 32'h1F);
  endtask

  task automatic t_start_checks();
    int bad, a0, req_seen = 0;
    init_mem();
    wr(A_SHIFT, 1);
    wr(A_CNT, 32'h1);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (mem_req) req_seen++; end
    chk(req_seen == 0, "R8 refused launch idle", 32'(req_seen), 0);
    rd_chk(A_STAT, 32'h04, "R8 small block flag");
    rd_chk(A_CNT, 32'h1, "R8 count left as written");
    wr(A_STAT, 32'h1F);
    wr(A_SHIFT, 4); wr(A_HOST, 32'h204);
    wr(A_CNT, 32'h1);
    rd_chk(A_STAT, 32'h10, "R8 misaligned host flag");
    wr(A_STAT, 32'h1F);
    wr(A_HOST, 32'h200); wr(A_BLK, 60);
    wr(A_CNT, 32'h5);
    rd_chk(A_STAT, 32'h08, "R8 range flag");
    wr(A_STAT, 32'h1F);
    wr(A_BLK, 54);
    a0 = wr_acks;
    wr(A_CNT, 32'h2);
    wait_done(2, 4, a0, bad);
    chk(bad == 0, "R8 exact-fit launch runs", 32'(bad), 0);
    rd_chk(A_STAT, 0, "R8 exact-fit no error");
    copy_chk(32'h3E0 / 4, 32'h200 / 4, 8, "R8 exact-fit copy");
  endtask

  initial begin
    init_mem();
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_copy();
    t_write_copy();
    t_aux();
    t_zero_count();
    t_busy();
    t_bus_err();
    t_start_checks();
    chk(r12_bad == 0, "R12 request held until ack", 32'(r12_bad), 0);
    finish_sim();
  end
endmodule